// File: doc/BRIEF.md
# Coprocessor-0 Exception and Interrupt Unit

This block holds the system-control state of a 32-bit MIPS-I style processor: the status word, the exception cause, the exception return address and a fixed processor-identity word. It decides when the core must leave its instruction stream. That happens on a synchronous fault reported by the pipeline, or on a peripheral interrupt that is both unmasked and enabled. When it decides, it produces a one-cycle redirect pulse together with the handler address.

On entry the unit records where to resume, taking branch-delay slots into account. It writes the fault code into the cause word and shifts a three-deep interrupt-enable/kernel-user stack, so the handler starts with interrupts off and in kernel mode. A return-from-exception strobe pops that stack. Peripheral request lines latch into a sticky interrupt-status register, which software acknowledges by writing zeros. The status register is combined with a mask register to form the external interrupt request.

Top module: `cp0_exc_unit`

## Requirements
- R1: After reset, redirectPc is 0xBFC00000, takeExc is 0, status reads 0x10900000, the identity word reads 0x00000002, and cause, EPC, interrupt-status and interrupt-mask read 0.
- R2: An excReq sampled at a clock edge makes takeExc high for the following cycle. Cause then holds its old bits 9:8, excCode in bits 6:2, and zeros in every other bit except BD.
- R3: With inDelaySlot high, cause bit 31 is set and EPC becomes curPc minus 4. With it low, bit 31 is 0 and EPC becomes curPc.
- R4: On entry, redirectPc becomes 0xBFC00180 when status bit 22 is 1, and 0x80000080 when it is 0.
- R5: On entry, status bits 5:0 become old bits 3:0 shifted left by two, and bits 31:6 are unchanged.
- R6: A rfeStrobe with no entry in the same cycle copies status bits 5:2 into bits 3:0 and leaves bits 31:4 unchanged.
- R7: When (interrupt-status AND interrupt-mask) is nonzero and status bits 10 and 0 are both 1, an interrupt entry follows one cycle later. Its cause keeps old bits 9:8, sets bit 10, and has code 0.
- R8: No interrupt entry occurs while the mask AND is zero, status bit 0 is 0, or status bit 10 is 0.
- R9: Interrupt-status bits are set by irqLines and stay set. A write ANDs the register with the data, so a 0 clears a bit and a 1 keeps it. A line that is high in the same cycle as a clearing write wins.
- R10: A synchronous request takes priority over a pending interrupt, and over an rfeStrobe, in the same cycle. The pending interrupt is taken the cycle after a later RFE re-enables it.
- R11: The register map is regAddr 0 status, 1 cause, 2 EPC, 3 identity, 4 interrupt-status, 5 interrupt-mask, and other addresses read 0. Cause writes change only bits 9:8. EPC and identity ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Synchronous exception request |
| excCode | input | 5 | Exception code for excReq |
| inDelaySlot | input | 1 | Faulting instruction is in a branch delay slot |
| curPc | input | 32 | PC of the interrupted instruction |
| rfeStrobe | input | 1 | Return-from-exception strobe |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 3 | Register select (see R11) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| irqLines | input | IRQ_W | Peripheral interrupt request lines |
| redirectPc | output | 32 | Fetch redirect address |
| takeExc | output | 1 | One-cycle exception entry pulse |

## Verification
A broken stack shift or pop shows up at the first RFE. A handler returns with the wrong enable bit, which appears as a missing or spurious takeExc on the cycle after the RFE. A stale BD or EPC value is visible on regRdData in the cycle right after the pulse. A wrong gating term in the interrupt path shows as a takeExc one cycle after a status or mask write that should have left it quiet. A lost acknowledge shows as an interrupt that fires again immediately after return.

// File: rtl/cp0_pkg.sv
package cp0_pkg;
  localparam int XLEN = 32;
  localparam logic [XLEN-1:0] RESET_PC     = 32'hBFC0_0000;
  localparam logic [XLEN-1:0] RESET_STATUS = 32'h1090_0000;
  localparam logic [XLEN-1:0] PROC_ID      = 32'h0000_0002;
  localparam logic [XLEN-1:0] VEC_BOOT     = 32'hBFC0_0180;
  localparam logic [XLEN-1:0] VEC_RAM      = 32'h8000_0080;
  localparam logic [XLEN-1:0] SWI_KEEP     = 32'h0000_0300;
  localparam logic [XLEN-1:0] HWI2_SET     = 32'h0000_0400;
  localparam int BEV_BIT = 22;
  localparam int IM2_BIT = 10;
  localparam int IEC_BIT = 0;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_CAUSE  = 3'd1,
    SEL_EPC    = 3'd2,
    SEL_PRID   = 3'd3,
    SEL_ISTAT  = 3'd4,
    SEL_IMASK  = 3'd5,
    SEL_RSV6   = 3'd6,
    SEL_RSV7   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic       take;
    logic       isIrq;
    logic       rfe;
    logic       bd;
    logic [4:0] code;
  } excStrobe_t;
endpackage

// File: rtl/cp0_ctrl.sv
module cp0_ctrl
  import cp0_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       excReq,
  input  logic [4:0] excCode,
  input  logic       inDelaySlot,
  input  logic       rfeStrobe,
  input  logic       irqRaw,
  input  logic       statusIec,
  input  logic       statusIm2,
  output excStrobe_t strobe,
  output logic       takeExc
);
  logic irqFire;

  // External interrupt needs a masked request, the current enable and IM2.
  assign irqFire = irqRaw & statusIec & statusIm2;

  always_comb begin
    strobe.take  = excReq | irqFire;
    strobe.isIrq = ~excReq & irqFire;   // synchronous fault wins
    strobe.rfe   = rfeStrobe;
    strobe.bd    = inDelaySlot;
    strobe.code  = excReq ? excCode : 5'd0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) takeExc <= 1'b0;
    else       takeExc <= strobe.take;
  end

  AST_TAKE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> takeExc); // R2

  AST_IRQ_NEEDS_IEC: assert property (@(posedge clk) disable iff (!rstN)
    (!excReq && !statusIec) |=> !takeExc); // R8

  AST_IRQ_NEEDS_IM2: assert property (@(posedge clk) disable iff (!rstN)
    (!excReq && !statusIm2) |=> !takeExc); // R8
endmodule

// File: rtl/cp0_regs.sv
module cp0_regs
  import cp0_pkg::*;
#(
  parameter int IRQ_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  excStrobe_t       strobe,
  input  logic [XLEN-1:0]  curPc,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [XLEN-1:0]  regWrData,
  input  logic [IRQ_W-1:0] irqLines,
  output logic [XLEN-1:0]  regRdData,
  output logic [XLEN-1:0]  redirectPc,
  output logic             irqRaw,
  output logic             statusIec,
  output logic             statusIm2
);
  logic [XLEN-1:0]  status, cause, epc, entryCause;
  logic [IRQ_W-1:0] irqStat, irqMask;
  regSel_e          sel;
  logic             wrStatus, wrCause, wrStat, wrMask;

  assign sel      = regSel_e'(regAddr);
  assign wrStatus = regWrEn && (sel == SEL_STATUS);
  assign wrCause  = regWrEn && (sel == SEL_CAUSE);
  assign wrStat   = regWrEn && (sel == SEL_ISTAT);
  assign wrMask   = regWrEn && (sel == SEL_IMASK);

  assign irqRaw    = |(irqStat & irqMask);
  assign statusIec = status[IEC_BIT];
  assign statusIm2 = status[IM2_BIT];

  always_comb begin
    entryCause = (cause & SWI_KEEP) | {25'd0, strobe.code, 2'b00};
    if (strobe.isIrq) entryCause = entryCause | HWI2_SET;
    if (strobe.bd)    entryCause[XLEN-1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status     <= RESET_STATUS;
      cause      <= '0;
      epc        <= '0;
      redirectPc <= RESET_PC;
    end else if (strobe.take) begin
      status     <= {status[XLEN-1:6], status[3:0], 2'b00};
      cause      <= entryCause;
      epc        <= strobe.bd ? curPc - 32'd4 : curPc;
      redirectPc <= status[BEV_BIT] ? VEC_BOOT : VEC_RAM;
    end else begin
      if (strobe.rfe)    status <= {status[XLEN-1:4], status[5:2]};
      else if (wrStatus) status <= regWrData;
      if (wrCause) cause <= (cause & ~SWI_KEEP) | (regWrData & SWI_KEEP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqStat <= '0;
      irqMask <= '0;
    end else begin
      irqStat <= (wrStat ? (irqStat & regWrData[IRQ_W-1:0]) : irqStat) | irqLines;
      if (wrMask) irqMask <= regWrData[IRQ_W-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS: regRdData = status;
      SEL_CAUSE:  regRdData = cause;
      SEL_EPC:    regRdData = epc;
      SEL_PRID:   regRdData = PROC_ID;
      SEL_ISTAT:  regRdData = XLEN'(irqStat);
      SEL_IMASK:  regRdData = XLEN'(irqMask);
      default:    regRdData = '0;
    endcase
  end

  AST_STACK_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> status[5:0] == {$past(status[3:0]), 2'b00}); // R5

  AST_STACK_POP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rfe && !strobe.take) |=> status[3:0] == $past(status[5:2])); // R6

  AST_EPC_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && strobe.bd) |=> (epc == $past(curPc) - 32'd4) && cause[XLEN-1]); // R3

  AST_VECTOR_BOOT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && status[BEV_BIT]) |=> redirectPc == VEC_BOOT); // R4

  AST_ISTAT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !wrStat |=> (irqStat & $past(irqStat)) == $past(irqStat)); // R9
endmodule

// File: rtl/cp0_exc_unit.sv
module cp0_exc_unit
  import cp0_pkg::*;
#(
  parameter int IRQ_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             excReq,
  input  logic [4:0]       excCode,
  input  logic             inDelaySlot,
  input  logic [31:0]      curPc,
  input  logic             rfeStrobe,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic [IRQ_W-1:0] irqLines,
  output logic [31:0]      redirectPc,
  output logic             takeExc
);
  excStrobe_t strobe;
  logic       irqRaw, statusIec, statusIm2;

  cp0_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excCode(excCode),
    .inDelaySlot(inDelaySlot), .rfeStrobe(rfeStrobe), .irqRaw(irqRaw),
    .statusIec(statusIec), .statusIm2(statusIm2),
    .strobe(strobe), .takeExc(takeExc)
  );

  cp0_regs #(.IRQ_W(IRQ_W)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curPc(curPc),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .irqLines(irqLines), .regRdData(regRdData), .redirectPc(redirectPc),
    .irqRaw(irqRaw), .statusIec(statusIec), .statusIm2(statusIm2)
  );
endmodule

// File: tb/tb_cp0_exc_unit.sv
`timescale 1ns/100ps
module tb_cp0_exc_unit;
  localparam int IRQ_W = 11;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             excReq = 1'b0;
  logic [4:0]       excCode = '0;
  logic             inDelaySlot = 1'b0;
  logic [31:0]      curPc = '0;
  logic             rfeStrobe = 1'b0;
  logic             regWrEn = 1'b0;
  logic [2:0]       regAddr = '0;
  logic [31:0]      regWrData = '0;
  logic [31:0]      regRdData;
  logic [IRQ_W-1:0] irqLines = '0;
  logic [31:0]      redirectPc;
  logic             takeExc;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  cp0_exc_unit #(.IRQ_W(IRQ_W)) dut (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excCode(excCode),
    .inDelaySlot(inDelaySlot), .curPc(curPc), .rfeStrobe(rfeStrobe),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqLines(irqLines),
    .redirectPc(redirectPc), .takeExc(takeExc)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    regAddr = a;
    #0.2;
    v = regRdData;
  endtask

  task automatic chkReg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic pulseIrq(input logic [IRQ_W-1:0] l);
    irqLines = l;
    tick();
    irqLines = '0;
  endtask

  task automatic raise(input logic [4:0] c, input logic [31:0] pc, input logic bd);
    excReq = 1'b1; excCode = c; curPc = pc; inDelaySlot = bd;
    tick();
    excReq = 1'b0; inDelaySlot = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 redirectPc", redirectPc, 32'hBFC0_0000);
    chk("R1 takeExc", 32'(takeExc), 32'd0);
    chkReg("R1 status", 3'd0, 32'h1090_0000);
    chkReg("R1 cause", 3'd1, 32'd0);
    chkReg("R1 epc", 3'd2, 32'd0);
    chkReg("R1 prid", 3'd3, 32'd2);
    chkReg("R1 istat", 3'd4, 32'd0);
    chkReg("R1 imask", 3'd5, 32'd0);
  endtask

  task automatic testRegMap();
    wr(3'd1, 32'hFFFF_FFFF);
    chkReg("R11 cause swi only", 3'd1, 32'h0000_0300);
    wr(3'd2, 32'h1111_1111);
    chkReg("R11 epc read only", 3'd2, 32'd0);
    wr(3'd3, 32'h2222_2222);
    chkReg("R11 prid read only", 3'd3, 32'd2);
    chkReg("R11 unmapped", 3'd7, 32'd0);
  endtask

  task automatic testSyncBoot();
    wr(3'd0, 32'h0040_000D);
    raise(5'h0A, 32'h1234_5678, 1'b0);
    chk("R2 take pulse", 32'(takeExc), 32'd1);
    chk("R4 boot vector", redirectPc, 32'hBFC0_0180);
    chkReg("R2 cause code", 3'd1, 32'h0000_0328);
    chkReg("R3 epc no delay", 3'd2, 32'h1234_5678);
    chkReg("R5 stack push", 3'd0, 32'h0040_0034);
    tick();
    chk("R2 pulse one cycle", 32'(takeExc), 32'd0);
  endtask

  task automatic testRfe();
    rfeStrobe = 1'b1;
    tick();
    rfeStrobe = 1'b0;
    chkReg("R6 stack pop", 3'd0, 32'h0040_003D);
    chk("R6 no entry", 32'(takeExc), 32'd0);
  endtask

  task automatic testDelayRam();
    wr(3'd0, 32'h0000_0001);
    raise(5'h04, 32'h8000_1000, 1'b1);
    chk("R2 take delay", 32'(takeExc), 32'd1);
    chk("R4 ram vector", redirectPc, 32'h8000_0080);
    chkReg("R3 cause bd", 3'd1, 32'h8000_0310);
    chkReg("R3 epc minus 4", 3'd2, 32'h8000_0FFC);
    chkReg("R5 push from 1", 3'd0, 32'h0000_0004);
  endtask

  task automatic testIrqGate();
    wr(3'd0, 32'h0000_0401);
    pulseIrq(11'h008);
    chkReg("R9 istat set", 3'd4, 32'h0000_0008);
    tick();
    chk("R8 mask zero", 32'(takeExc), 32'd0);
    wr(3'd0, 32'h0000_0400);
    wr(3'd5, 32'h0000_0008);
    tick();
    chk("R8 iec zero", 32'(takeExc), 32'd0);
    wr(3'd0, 32'h0000_0001);
    tick();
    chk("R8 im2 zero", 32'(takeExc), 32'd0);
    curPc = 32'h0000_2000;
    wr(3'd0, 32'h0000_0401);
    chk("R7 not before eval", 32'(takeExc), 32'd0);
    tick();
    chk("R7 irq taken", 32'(takeExc), 32'd1);
    chkReg("R7 irq cause", 3'd1, 32'h0000_0700);
    chkReg("R7 irq epc", 3'd2, 32'h0000_2000);
    chkReg("R7 irq status", 3'd0, 32'h0000_0404);
    chk("R7 irq vector", redirectPc, 32'h8000_0080);
    tick();
    chk("R7 no reentry", 32'(takeExc), 32'd0);
  endtask

  task automatic testAck();
    wr(3'd4, ~32'h0000_0008);
    chkReg("R9 ack clears", 3'd4, 32'd0);
    pulseIrq(11'h005);
    wr(3'd4, 32'hFFFF_FFFE);
    chkReg("R9 one keeps", 3'd4, 32'h0000_0004);
    irqLines = 11'h004;
    wr(3'd4, 32'd0);
    irqLines = '0;
    chkReg("R9 line beats clear", 3'd4, 32'h0000_0004);
    wr(3'd4, 32'd0);
    chkReg("R9 cleared", 3'd4, 32'd0);
  endtask

  task automatic testPriority();
    wr(3'd0, 32'h0000_0401);
    pulseIrq(11'h004);
    wr(3'd5, 32'h0000_0004);
    excReq = 1'b1; excCode = 5'h08; curPc = 32'h0000_3000; rfeStrobe = 1'b1;
    tick();
    excReq = 1'b0; rfeStrobe = 1'b0;
    chk("R10 sync taken", 32'(takeExc), 32'd1);
    chkReg("R10 sync code wins", 3'd1, 32'h0000_0320);
    chkReg("R10 push not pop", 3'd0, 32'h0000_0404);
    tick();
    chk("R10 irq held off", 32'(takeExc), 32'd0);
    rfeStrobe = 1'b1;
    tick();
    rfeStrobe = 1'b0;
    chkReg("R10 rfe restores", 3'd0, 32'h0000_0401);
    chk("R10 not same cycle", 32'(takeExc), 32'd0);
    tick();
    chk("R10 irq after rfe", 32'(takeExc), 32'd1);
    chkReg("R10 irq cause", 3'd1, 32'h0000_0700);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    testReset();
    testRegMap();
    testSyncBoot();
    testRfe();
    testDelayRam();
    testIrqGate();
    testAck();
    testPriority();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule